// File: doc/BRIEF.md
# SPI Serial EEPROM Responder

This block is a synthesizable model of a small serial EEPROM that answers on an SPI bus. It is the target for testing a host-side SPI controller: the host selects it with an active-low select line, clocks in an 8-bit command and, where the command needs one, a 16-bit address sent high byte first. It then either streams stored bytes back or accepts bytes to store. The storage is 8192 bytes arranged as 128 pages of 64 bytes.

Storing data takes two select frames. A first frame arms a write-enable latch, and a second frame carries the store command, the address and the data. Once select rises after at least one data byte, an internal write cycle of a set number of system clocks begins. During that cycle a busy flag is visible in the status byte and every command except the status read is ignored. When the cycle ends, the busy flag and the write-enable latch both clear. The SPI pins are oversampled by the system clock through a synchronizer, so the serial clock must run several times slower than the system clock.

Top module: `spi_eeprom_resp`

## Requirements
- R1: After reset the status byte reads 0x00 and miso is 0.
- R2: Command 0x06 sets the write-enable latch and command 0x04 clears it. The latch is status bit 1.
- R3: Command 0x01 followed by one byte loads status bits 7..2 from that byte only when the write-enable latch is set, and clears the latch when select rises. Without the latch the byte is dropped.
- R4: Command 0x03 with a 16-bit address returns consecutive bytes for as long as select stays low. Only the low 13 address bits are used, and reading past 0x1FFF continues at 0x0000.
- R5: Store data that passes the end of a 64-byte page continues at offset 0 of the same page. The next page is not touched.
- R6: Command 0x02 issued while the write-enable latch is clear stores nothing.
- R7: Select rising after a 0x02 frame that carried at least one data byte sets the busy flag (status bit 0). The flag clears after WR_CYCLES system clocks, and the write-enable latch clears with it.
- R8: While busy is set, every command except 0x05 is ignored: a read returns zeros and 0x06 has no effect.
- R9: A 0x02 frame that ends after the address, with no data byte, starts no write cycle and leaves the write-enable latch set.
- R10: miso is 0 whenever select has been high for four system clocks.
- R11: Select rising in the middle of a byte discards the partial byte, and the next frame decodes from its first bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data into the responder, MSB first |
| miso | output | 1 | Serial data from the responder, MSB first |

## Verification
Each SPI pin passes through two synchronizer flops and one edge-detect flop before it is used, and miso is registered. A bit of output therefore changes three system clocks after the falling sck edge that shifts it out. The bench holds each sck phase for four system clocks and samples miso just before the next rising edge. A read byte takes one more clock to fetch from memory after the previous byte completes, which still falls inside the same half period. The busy flag rises about three clocks after select rises, so the bench reads status right after a store frame to see busy set, then waits WR_CYCLES plus a margin before expecting it clear. The idle-miso rule is checked on every clock once select has been high for four clocks.

// File: rtl/spi_eep_pkg.sv
package spi_eep_pkg;
  localparam logic [7:0] CMD_WREN = 8'h06;
  localparam logic [7:0] CMD_WRDI = 8'h04;
  localparam logic [7:0] CMD_RDSR = 8'h05;
  localparam logic [7:0] CMD_WRSR = 8'h01;
  localparam logic [7:0] CMD_READ = 8'h03;
  localparam logic [7:0] CMD_PROG = 8'h02;

  typedef enum logic [2:0] {
    PH_CMD, PH_AHI, PH_ALO, PH_RDAT, PH_WDAT, PH_STAT, PH_SREG, PH_SKIP
  } phase_t;
endpackage

// File: rtl/spi_eep_sync.sv
module spi_eep_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  output logic cs_q,
  output logic mosi_q,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_rise
);
  logic [STAGES-1:0] cs_p, sck_p, mosi_p;
  logic cs_d, sck_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_p   <= '1;
      sck_p  <= '0;
      mosi_p <= '0;
      cs_d   <= 1'b1;
      sck_d  <= 1'b0;
    end else begin
      cs_p   <= {cs_p[STAGES-2:0], cs_n};
      sck_p  <= {sck_p[STAGES-2:0], sck};
      mosi_p <= {mosi_p[STAGES-2:0], mosi};
      cs_d   <= cs_p[STAGES-1];
      sck_d  <= sck_p[STAGES-1];
    end
  end

  assign cs_q     = cs_p[STAGES-1];
  assign mosi_q   = mosi_p[STAGES-1];
  assign sck_rise = sck_p[STAGES-1] & ~sck_d;
  assign sck_fall = ~sck_p[STAGES-1] & sck_d;
  assign cs_rise  = cs_p[STAGES-1] & ~cs_d;
endmodule

// File: rtl/spi_eep_mem.sv
module spi_eep_mem #(
  parameter int MEM_BYTES = 8192,
  parameter int LANES     = 4,
  localparam int AW    = $clog2(MEM_BYTES),
  localparam int LW    = $clog2(LANES),
  localparam int WORDS = MEM_BYTES / LANES
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [8*LANES-1:0] ram [WORDS];
  logic [8*LANES-1:0] word_q;
  logic [LW-1:0]      lane_q;

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (we && waddr[LW-1:0] == LW'(l))
        ram[waddr[AW-1:LW]][l*8 +: 8] <= wdata;
    end
    word_q <= ram[raddr[AW-1:LW]];
    lane_q <= raddr[LW-1:0];
  end

  assign rdata = word_q[lane_q*8 +: 8];
endmodule

// File: rtl/spi_eep_core.sv
module spi_eep_core
  import spi_eep_pkg::*;
#(
  parameter int MEM_BYTES  = 8192,
  parameter int PAGE_BYTES = 64,
  parameter int WR_CYCLES  = 1000,
  localparam int AW = $clog2(MEM_BYTES),
  localparam int PW = $clog2(PAGE_BYTES),
  localparam int TW = $clog2(WR_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_q,
  input  logic          mosi_q,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic          cs_rise,
  input  logic [7:0]    mem_q,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [7:0]    mem_wdata,
  output logic [AW-1:0] mem_raddr,
  output logic          miso,
  output logic          busy,
  output logic          wel
);
  phase_t        phase;
  logic [2:0]    bitcnt;
  logic [7:0]    rx_sh, tx_sh, tx_load, rx_next;
  logic [7:0]    addr_hi;
  logic [AW-1:0] ptr;
  logic [5:0]    user_bits;
  logic [TW-1:0] timer;
  logic          is_prog, got_data, sreg_done, byte_done;

  assign rx_next   = {rx_sh[6:0], mosi_q};
  assign byte_done = sck_rise && !cs_q && (bitcnt == 3'd7);
  assign mem_we    = byte_done && (phase == PH_WDAT);
  assign mem_waddr = ptr;
  assign mem_wdata = rx_next;
  assign mem_raddr = ptr;

  always_comb begin
    case (phase)
      PH_RDAT: tx_load = mem_q;
      PH_STAT: tx_load = {user_bits, wel, busy};
      default: tx_load = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_CMD; bitcnt <= '0; rx_sh <= '0; tx_sh <= '0;
      addr_hi <= '0; ptr <= '0; user_bits <= '0; timer <= '0;
      is_prog <= 1'b0; got_data <= 1'b0; sreg_done <= 1'b0;
      miso <= 1'b0; busy <= 1'b0; wel <= 1'b0;
    end else begin
      if (cs_q) begin
        phase <= PH_CMD; bitcnt <= '0; tx_sh <= '0; miso <= 1'b0;
        got_data <= 1'b0; sreg_done <= 1'b0;
        if (cs_rise && got_data) begin
          busy  <= 1'b1;
          timer <= TW'(WR_CYCLES - 1);
        end
        if (cs_rise && sreg_done) wel <= 1'b0;
      end else begin
        if (sck_rise) begin
          bitcnt <= bitcnt + 3'd1;
          rx_sh  <= rx_next;
        end
        if (byte_done) begin
          case (phase)
            PH_CMD: begin
              if (busy && rx_next != CMD_RDSR) phase <= PH_SKIP;
              else begin
                case (rx_next)
                  CMD_WREN: begin wel <= 1'b1; phase <= PH_SKIP; end
                  CMD_WRDI: begin wel <= 1'b0; phase <= PH_SKIP; end
                  CMD_RDSR: phase <= PH_STAT;
                  CMD_WRSR: phase <= wel ? PH_SREG : PH_SKIP;
                  CMD_READ: begin is_prog <= 1'b0; phase <= PH_AHI; end
                  CMD_PROG: begin is_prog <= 1'b1; phase <= wel ? PH_AHI : PH_SKIP; end
                  default:  phase <= PH_SKIP;
                endcase
              end
            end
            PH_AHI: begin addr_hi <= rx_next; phase <= PH_ALO; end
            PH_ALO: begin
              ptr   <= AW'({addr_hi, rx_next});
              phase <= is_prog ? PH_WDAT : PH_RDAT;
            end
            PH_RDAT: ptr <= ptr + 1'b1;
            PH_WDAT: begin
              got_data <= 1'b1;
              ptr <= {ptr[AW-1:PW], ptr[PW-1:0] + 1'b1};
            end
            PH_SREG: begin
              user_bits <= rx_next[7:2];
              sreg_done <= 1'b1;
              phase     <= PH_SKIP;
            end
            default: ;
          endcase
        end
        if (sck_fall) begin
          if (bitcnt == 3'd0) begin
            miso  <= tx_load[7];
            tx_sh <= {tx_load[6:0], 1'b0};
          end else begin
            miso  <= tx_sh[7];
            tx_sh <= {tx_sh[6:0], 1'b0};
          end
        end
      end
      if (busy) begin
        if (timer == '0) begin
          busy <= 1'b0;
          wel  <= 1'b0;
        end else begin
          timer <= timer - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_eeprom_resp.sv
module spi_eeprom_resp #(
  parameter int MEM_BYTES   = 8192,
  parameter int PAGE_BYTES  = 64,
  parameter int WR_CYCLES   = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  output logic miso
);
  localparam int AW = $clog2(MEM_BYTES);

  logic          cs_q, mosi_q, sck_rise, sck_fall, cs_rise;
  logic          mem_we, busy, wel;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [7:0]    mem_wdata, mem_q;

  spi_eep_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .cs_q(cs_q), .mosi_q(mosi_q), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .cs_rise(cs_rise)
  );

  spi_eep_core #(
    .MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES), .WR_CYCLES(WR_CYCLES)
  ) u_core (
    .clk(clk), .rst(rst), .cs_q(cs_q), .mosi_q(mosi_q),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_rise(cs_rise),
    .mem_q(mem_q), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .mem_raddr(mem_raddr),
    .miso(miso), .busy(busy), .wel(wel)
  );

  spi_eep_mem #(.MEM_BYTES(MEM_BYTES), .LANES(4)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_q)
  );
endmodule

// File: rtl/spi_eeprom_chk.sv
module spi_eeprom_chk (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic miso,
  input logic busy,
  input logic wel,
  input logic mem_we
);
  p_idle_miso_r10: assert property (@(posedge clk) disable iff (rst)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !miso)
    else $error("R10 miso driven while deselected");

  p_store_gated_r6: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (wel && !busy))
    else $error("R6 store without latch or while busy");

  p_busy_holds_wel_r7: assert property (@(posedge clk) disable iff (rst)
    busy |-> wel)
    else $error("R7 busy without write-enable latch");

  p_busy_end_clears_wel_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !wel)
    else $error("R7 latch survived end of write cycle");

  p_wren_ignored_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(wel))
    else $error("R8 latch changed during write cycle");
endmodule

bind spi_eeprom_resp spi_eeprom_chk u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .miso(miso),
  .busy(busy), .wel(wel), .mem_we(mem_we)
);

// File: tb/spi_eeprom_resp_test.sv
`timescale 1ns/1ps
module spi_eeprom_resp_test;
  localparam int WR = 2000;
  localparam int H  = 4;

  logic clk = 1'b0, rst = 1'b1, cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso;
  int checks = 0, errors = 0, idle_cnt = 0;
  bit done = 1'b0;

  byte unsigned mdl [int];
  bit mdl_wel = 1'b0, mdl_busy = 1'b0;
  bit [5:0] mdl_user = '0;

  always #2.5 clk = ~clk;

  spi_eeprom_resp #(.WR_CYCLES(WR)) uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // R10: per-clock idle check against the model of select
  always @(negedge clk) begin
    if (rst || !cs_n) idle_cnt = 0;
    else idle_cnt++;
    if (idle_cnt >= 4 && !done) chk("R10 idle miso", int'(miso), 0);
  end

  task automatic xbyte(input logic [7:0] t, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      mosi = t[i];
      repeat (H) @(negedge clk);
      r[i] = miso;
      sck = 1'b1;
      repeat (H) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic sel();
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic desel();
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic op1(input logic [7:0] c);
    logic [7:0] r;
    sel(); xbyte(c, r); desel();
  endtask

  task automatic wren();
    op1(8'h06);
    if (!mdl_busy) mdl_wel = 1'b1;
  endtask

  task automatic wrdi();
    op1(8'h04);
    if (!mdl_busy) mdl_wel = 1'b0;
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] r;
    sel(); xbyte(8'h01, r); xbyte(v, r); desel();
    if (mdl_wel && !mdl_busy) begin
      mdl_user = v[7:2];
      mdl_wel  = 1'b0;
    end
  endtask

  task automatic status(input string req);
    logic [7:0] r;
    sel(); xbyte(8'h05, r); xbyte(8'h00, r); desel();
    chk(req, int'(r), int'({mdl_user, mdl_wel, mdl_busy}));
  endtask

  task automatic prog(input logic [15:0] a, input byte unsigned d[$]);
    logic [7:0] r;
    sel(); xbyte(8'h02, r); xbyte(a[15:8], r); xbyte(a[7:0], r);
    foreach (d[i]) xbyte(d[i], r);
    desel();
    if (mdl_wel && !mdl_busy && d.size() > 0) begin
      foreach (d[i]) mdl[{a[12:6], 6'(a[5:0] + i)}] = d[i];
      mdl_busy = 1'b1;
    end
  endtask

  task automatic rd(input string req, input logic [15:0] a, input int n);
    logic [7:0] r;
    int exp;
    sel(); xbyte(8'h03, r); xbyte(a[15:8], r); xbyte(a[7:0], r);
    for (int i = 0; i < n; i++) begin
      xbyte(8'h00, r);
      exp = mdl_busy ? 0 : int'(mdl[(int'(a) + i) % 8192]);
      chk(req, int'(r), exp);
    end
    desel();
  endtask

  task automatic settle();
    repeat (WR + 50) @(negedge clk);
    if (mdl_busy) begin
      mdl_busy = 1'b0;
      mdl_wel  = 1'b0;
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 miso after reset", int'(miso), 0);
    status("R1 status after reset");

    wren();  status("R2 latch set");
    wrdi();  status("R2 latch cleared");

    wrsr(8'hFC); status("R3 status write without latch");
    wren(); wrsr(8'hFF); status("R3 status write with latch");
    wren(); wrsr(8'h00); status("R3 status bits cleared");

    wren();
    prog(16'h0100, '{8'h01, 8'h04, 8'h07, 8'h0A, 8'h0D, 8'h10});
    status("R7 busy and latch during write cycle");
    settle();
    status("R7 busy and latch clear after cycle");
    rd("R4 sequential read", 16'h0100, 6);

    prog(16'h0100, '{8'hEE, 8'hDD});
    settle();
    rd("R6 store without latch dropped", 16'h0100, 2);

    wren(); prog(16'h0300, '{8'h5A}); settle();
    wren();
    prog(16'h02FC, '{8'hA0, 8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hA5, 8'hA6, 8'hA7});
    settle();
    rd("R5 page wrap tail and next page untouched", 16'h02FC, 5);
    rd("R5 page wrap head", 16'h02C0, 4);

    wren(); prog(16'h1FFE, '{8'h3C, 8'hC3}); settle();
    wren(); prog(16'h0000, '{8'h99}); settle();
    rd("R4 read wraps at array end", 16'h1FFE, 3);
    rd("R4 upper address bits ignored", 16'hFFFE, 3);

    wren(); prog(16'h0400, '{8'h11});
    wren();
    rd("R8 read ignored while busy", 16'h0100, 2);
    status("R8 status readable while busy");
    settle();
    status("R8 latch not set by command during busy");
    rd("R7 stored byte after cycle", 16'h0400, 1);

    wren(); prog(16'h0500, '{});
    status("R9 address-only store frame");
    wrdi();

    sel();
    for (int i = 0; i < 3; i++) begin
      mosi = 1'b1;
      repeat (H) @(negedge clk);
      sck = 1'b1;
      repeat (H) @(negedge clk);
      sck = 1'b0;
    end
    desel();
    status("R11 status after aborted frame");
    wren(); status("R11 command decodes after abort");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    done = 1'b1;
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule